// File: doc/BRIEF.md
# Reciprocal-Constant Modular Reducer

This block reduces a double-width unsigned value modulo a single-width modulus, without a divider in the data path. Before any request, the modulus and a reciprocal constant are loaded together through a configuration port. The constant is the integer part of 2^(2K) divided by the modulus, and it is computed outside the block. Once configured, each request carries one 2K-bit operand. After a few cycles the block returns the K-bit remainder with a single-cycle completion pulse.

Internally a small state machine runs the reduction in stages:

1. It multiplies the upper bits of the operand (operand shifted right by K-1) by the stored constant. Shifting that product right by K+1 gives a quotient estimate that never exceeds the true quotient and falls short of it by at most two.
2. It multiplies the estimate back by the modulus and subtracts the result from the operand.
3. It trims the difference with at most two compare-and-subtract steps, one per cycle.

The block only accepts a modulus whose top bit is set. Any other modulus raises an error flag when it is loaded, and requests are then refused.

Top module: `mod_reducer`

## Requirements
- R1: After synchronous reset, `done`, `busy`, `cfg_err` and `r_out` are all 0.
- R2: A configuration load taken while idle sets `cfg_err` to 1 on the next cycle when bit K-1 of `cfg_mod` is 0, and clears it to 0 when that bit is 1.
- R3: While no valid modulus is held (none loaded since reset, or the last load raised `cfg_err`), `start` is ignored: `busy` stays 0 and no `done` pulse follows.
- R4: For any operand 0 <= x < 2^(2K) and a loaded modulus m with 2^(K-1) <= m < 2^K, the returned `r_out` equals x mod m.
- R5: The quotient estimate leaves a difference below 3m, so at most two corrective subtractions are made before the result is returned.
- R6: `done` rises between 4 and 6 clock edges after the edge that accepts `start`.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored: no extra `done` follows, and the running result is unaffected.
- R8: A configuration load that arrives while `busy` is 1 is ignored; the previously loaded modulus and constant stay in force.
- R9: `done` is high for exactly one cycle, and `r_out` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load modulus and reciprocal constant |
| cfg_mod | input | K | Modulus; top bit must be 1 |
| cfg_mu | input | K+2 | floor(2^(2K) / modulus) |
| start | input | 1 | Request a reduction of `x_in` |
| x_in | input | 2K | Operand to reduce |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle pulse: `r_out` is new |
| r_out | output | K | Remainder, below the modulus |
| cfg_err | output | 1 | Last load had a modulus out of range |

## Verification
The assertions assume that `cfg_mu` is the exact floor of 2^(2K) divided by `cfg_mod`. The bounds on the difference and on the correction count follow only from that pairing, and the block does not check it. The bench derives the constant from each modulus it loads, using full-width division in the bench itself, so every accepted configuration is consistent. Out-of-range moduli are loaded only to exercise the error flag, and they are never paired with a reduction that is expected to run.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_EST,
    S_BACK,
    S_SUB,
    S_FIX
  } mdr_state_e;
endpackage

// File: rtl/mdr_cfg.sv
module mdr_cfg #(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         idle_i,
  input  logic [K-1:0] mod_i,
  input  logic [K+1:0] mu_i,
  output logic [K-1:0] mod_o,
  output logic [K+1:0] mu_o,
  output logic         valid_o,
  output logic         err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_o   <= '0;
      mu_o    <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (load_i && idle_i) begin
      mod_o   <= mod_i;
      mu_o    <= mu_i;
      valid_o <= mod_i[K-1];
      err_o   <= ~mod_i[K-1];
    end
  end

  p_err_range_r2: assert property (@(posedge clk) disable iff (rst)
    (load_i && idle_i) |=> (err_o == !$past(mod_i[K-1])));

  p_load_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (load_i && !idle_i) |=> ($stable(mod_o) && $stable(mu_o)));
endmodule

// File: rtl/mdr_mul.sv
module mdr_mul #(
  parameter int AW = 33,
  parameter int BW = 34,
  localparam int PW = AW + BW
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] p
);
  always_ff @(posedge clk) begin
    if (en) p <= PW'(a) * PW'(b);
  end
endmodule

// File: rtl/mdr_fix.sv
module mdr_fix #(
  parameter int K = 32,
  localparam int RW = K + 2
) (
  input  logic [RW-1:0] rem_i,
  input  logic [K-1:0]  mod_i,
  output logic          ge_o,
  output logic [RW-1:0] nxt_o
);
  logic [RW-1:0] mod_ext;
  always_comb begin
    mod_ext = {2'b00, mod_i};
    ge_o    = rem_i >= mod_ext;
    nxt_o   = rem_i - mod_ext;
  end
endmodule

// File: rtl/mod_reducer.sv
module mod_reducer #(
  parameter int K = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_load,
  input  logic [K-1:0]   cfg_mod,
  input  logic [K+1:0]   cfg_mu,
  input  logic           start,
  input  logic [2*K-1:0] x_in,
  output logic           busy,
  output logic           done,
  output logic [K-1:0]   r_out,
  output logic           cfg_err
);
  import mdr_pkg::*;

  localparam int XW  = 2 * K;
  localparam int HW  = K + 1;
  localparam int MUW = K + 2;
  localparam int P1W = HW + MUW;
  localparam int QW  = P1W - (K + 1);
  localparam int P2W = QW + K;
  localparam int RW  = K + 2;

  mdr_state_e     state;
  logic [XW-1:0]  x_q;
  logic [RW-1:0]  rem_q;
  logic [1:0]     fix_cnt;
  logic           done_q;
  logic [K-1:0]   r_q;

  logic [K-1:0]   mod_w;
  logic [K+1:0]   mu_w;
  logic           cfg_ok;
  logic           idle;
  logic [P1W-1:0] p1;
  logic [P2W-1:0] p2;
  logic [QW-1:0]  q_est;
  logic [P2W-1:0] diff;
  logic           ge;
  logic [RW-1:0]  rem_nxt;

  assign idle  = (state == S_IDLE);
  assign q_est = p1[P1W-1:K+1];
  assign diff  = {{(P2W-XW){1'b0}}, x_q} - p2;

  mdr_cfg #(.K(K)) u_cfg (
    .clk(clk), .rst(rst), .load_i(cfg_load), .idle_i(idle),
    .mod_i(cfg_mod), .mu_i(cfg_mu),
    .mod_o(mod_w), .mu_o(mu_w), .valid_o(cfg_ok), .err_o(cfg_err)
  );

  mdr_mul #(.AW(HW), .BW(MUW)) u_mul_est (
    .clk(clk), .en(state == S_EST),
    .a(x_q[XW-1:K-1]), .b(mu_w), .p(p1)
  );

  mdr_mul #(.AW(QW), .BW(K)) u_mul_back (
    .clk(clk), .en(state == S_BACK),
    .a(q_est), .b(mod_w), .p(p2)
  );

  mdr_fix #(.K(K)) u_fix (
    .rem_i(rem_q), .mod_i(mod_w), .ge_o(ge), .nxt_o(rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      x_q     <= '0;
      rem_q   <= '0;
      fix_cnt <= '0;
      done_q  <= 1'b0;
      r_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && cfg_ok) begin
            x_q   <= x_in;
            state <= S_EST;
          end
        end
        S_EST:  state <= S_BACK;
        S_BACK: state <= S_SUB;
        S_SUB: begin
          rem_q   <= diff[RW-1:0];
          fix_cnt <= '0;
          state   <= S_FIX;
        end
        S_FIX: begin
          if (ge) begin
            rem_q   <= rem_nxt;
            fix_cnt <= fix_cnt + 2'd1;
          end else begin
            r_q    <= rem_q[K-1:0];
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = !idle;
  assign done  = done_q;
  assign r_out = r_q;

  p_est_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIX && fix_cnt == 2'd0) |->
      (rem_q < ({2'b00, mod_w} + {2'b00, mod_w} + {2'b00, mod_w})));

  p_corr_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIX && fix_cnt == 2'd2) |-> !ge);

  p_rem_below_mod_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (r_out < mod_w));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(r_out));

  p_no_start_invalid_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && !cfg_ok) |=> !busy);
endmodule

// File: tb/mod_reducer_tb.sv
module mod_reducer_tb;
  localparam int K = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_load = 1'b0;
  logic [K-1:0]   cfg_mod = '0;
  logic [K+1:0]   cfg_mu = '0;
  logic           start = 1'b0;
  logic [2*K-1:0] x_in = '0;
  logic           busy, done, cfg_err;
  logic [K-1:0]   r_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mod_reducer #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_mod(cfg_mod),
    .cfg_mu(cfg_mu), .start(start), .x_in(x_in), .busy(busy),
    .done(done), .r_out(r_out), .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [K+1:0] mu_of(logic [K-1:0] m);
    logic [2*K+1:0] num;
    num = '0;
    num[2*K] = 1'b1;
    return (K+2)'(num / {{(K+2){1'b0}}, m});
  endfunction

  task automatic load_cfg(logic [K-1:0] m);
    @(negedge clk);
    cfg_mod  = m;
    cfg_mu   = mu_of(m);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic reduce(logic [2*K-1:0] x, logic [K-1:0] m, string req);
    int lat;
    logic [K-1:0] held;
    @(negedge clk);
    x_in  = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
    end
    check({req, " R4 remainder"}, 64'(r_out), x % {{K{1'b0}}, m});
    check("R6/R5 latency within 4..6", 64'(lat >= 4 && lat <= 6), 64'd1);
    held = r_out;
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 64'd0);
    check("R9 result held", 64'(r_out), 64'(held));
  endtask

  task automatic t_reset;
    check("R1 done", 64'(done), 0);
    check("R1 busy", 64'(busy), 0);
    check("R1 cfg_err", 64'(cfg_err), 0);
    check("R1 r_out", 64'(r_out), 0);
  endtask

  task automatic t_no_config;
    int seen;
    seen = 0;
    @(negedge clk);
    x_in = 64'd12345;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (busy || done) seen++;
      @(negedge clk);
    end
    check("R3 start ignored without modulus", 64'(seen), 0);
  endtask

  task automatic t_bad_modulus;
    int seen;
    load_cfg(32'h7FFF_FFFF);
    check("R2 error on small modulus", 64'(cfg_err), 1);
    seen = 0;
    @(negedge clk);
    x_in = 64'd99;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (busy || done) seen++;
      @(negedge clk);
    end
    check("R3 start ignored after bad load", 64'(seen), 0);
    load_cfg(32'h8000_0000);
    check("R2 error cleared on valid modulus", 64'(cfg_err), 0);
  endtask

  task automatic t_boundaries;
    logic [K-1:0] m;
    m = 32'h8000_0000;
    load_cfg(m);
    reduce(64'hFFFF_FFFF_FFFF_FFFF, m, "min modulus, max x");
    reduce(64'h0, m, "zero x");
    m = 32'hFFFF_FFFB;
    load_cfg(m);
    reduce(64'hFFFF_FFFF_FFFF_FFFF, m, "max x");
    reduce(64'(m) * 64'hFFFF_FFFF, m, "exact multiple");
    reduce(64'(m) - 64'd1, m, "m-1");
    reduce(64'(m), m, "x equals m");
    reduce(64'(m) * 64'hFFFF_FFFF - 64'd1, m, "multiple minus one");
  endtask

  task automatic t_random;
    logic [K-1:0] m;
    logic [2*K-1:0] x;
    for (int j = 0; j < 6; j++) begin
      m = $urandom | 32'h8000_0000;
      load_cfg(m);
      for (int i = 0; i < 8; i++) begin
        x = {$urandom, $urandom};
        reduce(x, m, "random");
      end
      reduce(64'(m) * 64'($urandom), m, "random exact multiple");
    end
  endtask

  task automatic t_busy_ignores;
    logic [K-1:0] m;
    logic [2*K-1:0] x;
    int pulses;
    m = 32'hC000_0011;
    x = 64'h1234_5678_9ABC_DEF0;
    load_cfg(m);
    @(negedge clk);
    x_in = x;
    start = 1'b1;
    @(negedge clk);
    x_in = 64'hFFFF_0000_FFFF_0000;
    cfg_mod = 32'h9000_0001;
    cfg_mu = mu_of(32'h9000_0001);
    cfg_load = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_load = 1'b0;
    pulses = 0;
    for (int i = 0; i < 15; i++) begin
      if (done) begin
        pulses++;
        check("R7 running result kept", 64'(r_out), x % {32'b0, m});
      end
      @(negedge clk);
    end
    check("R7 single completion", 64'(pulses), 1);
    reduce(64'hFEDC_BA98_7654_3210, m, "R8 old modulus still in force");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_config();
    t_bad_modulus();
    t_boundaries();
    t_random();
    t_busy_ignores();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule